// File: doc/BRIEF.md
# Dual-Adder Interleaved Row Reducer

This block turns a stream of tagged values into one sum per row. Each input word carries a value, a row tag and a flag that marks the last word of its row. The words of one row arrive back to back. The next row may start on the very next cycle. The block holds no large buffer and never stalls the pipeline to flush between rows. Two adder lanes share the work. Each lane has a fixed-latency integer adder and its own three-state controller. Several rows can therefore be partly reduced at the same moment.

Incoming words first enter a small input FIFO. The head word goes to the lane that owns its row. Rows are dealt to the two lanes in turn, by arrival order. Inside a lane, the adder output is fed back. New words are combined with partial sums that come back from the pipeline, and leftover partials wait in a stack of at most L entries. Once the last word of a row has been accepted, the lane folds its remaining partials together. When exactly one partial is left, the lane emits it with the row tag.

A short row can finish before a longer row that arrived earlier, so every result carries its tag. Short rows drain the FIFO more slowly than they fill it. A throttle output with hysteresis therefore tells the source to pause before the FIFO overflows.

The lane controller has three states. FILL is an idle lane, or a lane that has started a row and has no partial returned yet. STEADY is a lane whose open row already has partials coming back. COALESCE is a lane that has accepted its last word and is folding partials. The transitions are:
- FILL to STEADY when the first partial returns from the pipeline.
- FILL or STEADY to COALESCE when the last word of the row is accepted.
- COALESCE to FILL when the single remaining partial is emitted.

Top module: `row_reduce2`

## Requirements
- R1: For every row, exactly one result is emitted. It carries the row's tag on `out_row`, and `out_sum` equals the sum of all the row's values modulo 2^W. A result appears as a one-cycle pulse on `out_valid`.
- R2: Rows are assigned to lanes in arrival order from reset. The k-th row, counting from 0, goes to lane k mod 2.
- R3: Each lane is always in FILL, STEADY or COALESCE and follows the named transitions. Rows of any length, including rows longer than the adder latency, reduce correctly.
- R4: A lane in COALESCE accepts no new word. A following row for that lane waits in the FIFO and is emitted after the lane's current row.
- R5: On an idle block, a single-word row is emitted unchanged (its value added to zero). It appears on the outputs L+1 clock edges after the edge that writes it.
- R6: Results may leave out of arrival order. A single-word row on lane 1 that follows a 12-word row on lane 0 is emitted before that 12-word row.
- R7: When both lanes are ready to emit in the same cycle, lane 0 emits first. Lane 1 keeps its sum and emits on the following cycle, and nothing is lost.
- R8: `throttle` rises on the edge after FIFO occupancy is at least DEPTH-2L. It falls on the edge after occupancy is below DEPTH/2. A source that stops while `throttle` is high never overflows the FIFO.
- R9: After reset, `out_valid` and `throttle` are low and the FIFO is empty.
- R10: Rows written back to back, with no idle cycle between them and of mixed lengths, all reduce correctly without any flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present this cycle |
| in_value | input | W | Value to add into its row |
| in_row | input | RW | Row tag of the word |
| in_last | input | 1 | Word is the last of its row |
| throttle | output | 1 | Source must pause while high |
| out_valid | output | 1 | One-cycle pulse: a row sum is on the outputs |
| out_sum | output | W | Row sum modulo 2^W |
| out_row | output | RW | Tag of the row being emitted |

## Verification
The reduction is tried with several input patterns:
- A lone single-word row, which pins down the exact pass-through latency.
- A two-word row with a single-word row placed so that both lanes finish on the same cycle, which separates correct output arbitration from a lane that drops or overwrites its sum.
- A long row followed by two short ones, which shows both out-of-order completion and a lane holding back a waiting row while it coalesces.
- A long burst of single-word rows, which drives the FIFO to its high mark to exercise the throttle.
- A back-to-back stream of random lengths and values, which compares every sum against an independent per-tag model, including sums that wrap.

// File: rtl/rowred_pkg.sv
package rowred_pkg;
    typedef enum logic [1:0] {
        ST_FILL     = 2'd0,
        ST_STEADY   = 2'd1,
        ST_COALESCE = 2'd2
    } lane_state_t;
endpackage

// File: rtl/rowred_fifo.sv
module rowred_fifo #(
    parameter int EW    = 41,
    parameter int DEPTH = 32,
    parameter int HI    = 24,
    parameter int LO    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] push_data,
    input  logic          pop,
    output logic [EW-1:0] head,
    output logic          nonempty,
    output logic          throttle
);
    localparam int AW = $clog2(DEPTH);
    localparam int CNTW = AW + 1;

    logic [EW-1:0]   mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] count;
    logic            do_push, do_pop;

    assign do_push  = push && (count != CNTW'(DEPTH));
    assign do_pop   = pop && nonempty;
    assign nonempty = (count != '0);
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            throttle <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNTW'(do_push) - CNTW'(do_pop);
            if (count >= CNTW'(HI))
                throttle <= 1'b1;
            else if (count < CNTW'(LO))
                throttle <= 1'b0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CNTW'(DEPTH))); // R8
    AST_THR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= CNTW'(HI)) |=> throttle); // R8
endmodule

// File: rtl/rowred_addpipe.sv
module rowred_addpipe #(
    parameter int W  = 32,
    parameter int RW = 8,
    parameter int L  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    input  logic [RW-1:0] in_row,
    output logic          out_v,
    output logic [W-1:0]  out_sum,
    output logic [RW-1:0] out_row
);
    logic          v_q [L];
    logic [W-1:0]  s_q [L];
    logic [RW-1:0] r_q [L];

    generate
        for (genvar st = 0; st < L; st++) begin : g_stage
            if (st == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) v_q[0] <= 1'b0;
                    else        v_q[0] <= in_v;
                end
                always_ff @(posedge clk) begin
                    s_q[0] <= in_a + in_b;
                    r_q[0] <= in_row;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) v_q[st] <= 1'b0;
                    else        v_q[st] <= v_q[st-1];
                end
                always_ff @(posedge clk) begin
                    s_q[st] <= s_q[st-1];
                    r_q[st] <= r_q[st-1];
                end
            end
        end
    endgenerate

    assign out_v   = v_q[L-1];
    assign out_sum = s_q[L-1];
    assign out_row = r_q[L-1];
endmodule

// File: rtl/rowred_lane.sv
module rowred_lane
    import rowred_pkg::*;
#(
    parameter int W  = 32,
    parameter int RW = 8,
    parameter int L  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_val,
    input  logic [RW-1:0] in_row,
    input  logic          in_last,
    input  logic          grant,
    output logic          can_take,
    output logic          emit_req,
    output logic [W-1:0]  emit_val,
    output logic [RW-1:0] emit_row
);
    localparam int CW = $clog2(L + 1);
    localparam int IW = (L > 1) ? $clog2(L) : 1;

    lane_state_t   state, state_nxt;
    logic [W-1:0]  stk [L];
    logic [CW-1:0] stk_n, t_cnt;
    logic [CW-1:0] i_top, i_sec;
    logic [CW:0]   n_s;
    logic [RW-1:0] cur_row;
    logic          p_v;
    logic [W-1:0]  p_sum, op1, op2, add_a, add_b;
    logic [RW-1:0] p_row;
    logic          issue;
    logic [1:0]    used;

    rowred_addpipe #(.W(W), .RW(RW), .L(L)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_v(issue), .in_a(add_a), .in_b(add_b),
        .in_row(in_valid ? in_row : cur_row),
        .out_v(p_v), .out_sum(p_sum), .out_row(p_row)
    );

    assign i_top = stk_n - 1'b1;
    assign i_sec = stk_n - 2'd2;
    assign n_s   = {1'b0, stk_n} + (CW+1)'(p_v);
    assign op1   = p_v ? p_sum : stk[i_top[IW-1:0]];
    assign op2   = p_v ? stk[i_top[IW-1:0]] : stk[i_sec[IW-1:0]];
    assign can_take = (state != ST_COALESCE);
    assign emit_row = cur_row;

    // Operand selection: new word first, then pairs of partials, then emit
    always_comb begin
        issue    = 1'b0;
        add_a    = '0;
        add_b    = '0;
        used     = 2'd0;
        emit_req = 1'b0;
        emit_val = op1;
        if (in_valid) begin
            issue = 1'b1;
            add_a = in_val;
            add_b = (n_s != '0) ? op1 : '0;
            used  = (n_s != '0) ? 2'd1 : 2'd0;
        end else if (n_s >= (CW+1)'(2)) begin
            issue = 1'b1;
            add_a = op1;
            add_b = op2;
            used  = 2'd2;
        end else if (state == ST_COALESCE && n_s == (CW+1)'(1) && t_cnt == CW'(1)) begin
            emit_req = 1'b1;
            used     = grant ? 2'd1 : 2'd0;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FILL: begin
                if (in_valid && in_last) state_nxt = ST_COALESCE;
                else if (p_v)            state_nxt = ST_STEADY;
            end
            ST_STEADY: begin
                if (in_valid && in_last) state_nxt = ST_COALESCE;
            end
            ST_COALESCE: begin
                if (emit_req && grant)   state_nxt = ST_FILL;
            end
            default: state_nxt = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_n   <= '0;
            t_cnt   <= '0;
            cur_row <= '0;
        end else begin
            stk_n <= stk_n + CW'(p_v) - CW'(used);
            t_cnt <= t_cnt + CW'(issue) - CW'(used);
            if (in_valid) cur_row <= in_row;
        end
    end

    always_ff @(posedge clk) begin
        if (p_v && used == 2'd0) stk[stk_n[IW-1:0]] <= p_sum;
    end

    AST_T_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        t_cnt <= CW'(L)); // R1
    AST_COAL_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COALESCE) |-> !in_valid); // R4
    AST_FILL_AFTER_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_req && grant) |=> (state == ST_FILL && t_cnt == '0)); // R3
    AST_TAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        p_v |-> (p_row == cur_row)); // R1
endmodule

// File: rtl/row_reduce2.sv
module row_reduce2 #(
    parameter int W     = 32,
    parameter int RW    = 8,
    parameter int L     = 4,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_value,
    input  logic [RW-1:0] in_row,
    input  logic          in_last,
    output logic          throttle,
    output logic          out_valid,
    output logic [W-1:0]  out_sum,
    output logic [RW-1:0] out_row
);
    localparam int EW = W + RW + 1;
    localparam int HI = DEPTH - 2 * L;
    localparam int LO = DEPTH / 2;
    localparam int NL = 2;

    logic [EW-1:0] head;
    logic          nonempty, pop, owner;
    logic          h_last;
    logic [RW-1:0] h_row;
    logic [W-1:0]  h_val;
    logic          take  [NL];
    logic          l_in  [NL];
    logic          grant [NL];
    logic          emit  [NL];
    logic [W-1:0]  e_val [NL];
    logic [RW-1:0] e_row [NL];

    rowred_fifo #(.EW(EW), .DEPTH(DEPTH), .HI(HI), .LO(LO)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(in_valid), .push_data({in_last, in_row, in_value}),
        .pop(pop), .head(head), .nonempty(nonempty), .throttle(throttle)
    );

    assign {h_last, h_row, h_val} = head;
    assign pop = nonempty && take[owner];

    generate
        for (genvar g = 0; g < NL; g++) begin : g_lane
            assign l_in[g]  = pop && (owner == 1'(g));
            if (g == 0) begin : g_pri
                assign grant[g] = 1'b1;
            end else begin : g_sub
                assign grant[g] = !emit[0];
            end
            rowred_lane #(.W(W), .RW(RW), .L(L)) u_lane (
                .clk(clk), .rst_n(rst_n),
                .in_valid(l_in[g]), .in_val(h_val), .in_row(h_row), .in_last(h_last),
                .grant(grant[g]), .can_take(take[g]),
                .emit_req(emit[g]), .emit_val(e_val[g]), .emit_row(e_row[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner     <= 1'b0;
            out_valid <= 1'b0;
            out_sum   <= '0;
            out_row   <= '0;
        end else begin
            if (pop && h_last) owner <= ~owner;
            out_valid <= emit[0] || emit[1];
            out_sum   <= emit[0] ? e_val[0] : e_val[1];
            out_row   <= emit[0] ? e_row[0] : e_row[1];
        end
    end

    AST_LANE1_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (emit[0] && emit[1]) |=> emit[1]); // R7
    AST_OUT_FROM_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(emit[0] || emit[1])); // R1
    AST_POP_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && h_last) |=> (owner != $past(owner))); // R2
endmodule

// File: tb/row_reduce2_tb_top.sv
module row_reduce2_tb_top;
    localparam int W = 32, RW = 8, L = 4, DEPTH = 32;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          in_valid = 1'b0, in_last = 1'b0;
    logic [W-1:0]  in_value = '0;
    logic [RW-1:0] in_row = '0;
    logic          throttle, out_valid;
    logic [W-1:0]  out_sum;
    logic [RW-1:0] out_row;

    int checks = 0, errors = 0, cyc = 0, rows_sent = 0;
    int tag_next = 0;
    logic [W-1:0] exp_sum [256];
    bit           pend [256];
    int           out_q [$];
    int           out_c [$];
    bit           saw_thr = 1'b0;

    row_reduce2 #(.W(W), .RW(RW), .L(L), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_row(in_row), .in_last(in_last), .throttle(throttle),
        .out_valid(out_valid), .out_sum(out_sum), .out_row(out_row)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Reference scoreboard: every cycle, any output must match an open row
    always @(negedge clk) begin
        if (rst_n) begin
            if (throttle) saw_thr = 1'b1;
            if (out_valid) begin
                chk(pend[out_row], "R1", "result for a row not open", out_row, 0);
                chk(out_sum == exp_sum[out_row], "R1", "row sum", out_sum, exp_sum[out_row]);
                pend[out_row] = 1'b0;
                out_q.push_back(int'(out_row));
                out_c.push_back(cyc);
            end
        end
    end

    task automatic put(input logic [W-1:0] v, input logic [RW-1:0] r, input bit last);
        while (throttle) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b1; in_value = v; in_row = r; in_last = last;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic open_row(output int tag);
        tag = tag_next;
        tag_next = (tag_next + 1) % 256;
        exp_sum[tag] = '0;
        pend[tag] = 1'b1;
        rows_sent++;
    endtask

    task automatic send_row(input int len, output int tag);
        logic [W-1:0] v;
        open_row(tag);
        for (int k = 0; k < len; k++) begin
            v = $urandom;
            exp_sum[tag] = exp_sum[tag] + v;
            put(v, RW'(tag), k == len - 1);
        end
    endtask

    task automatic drain(input string req);
        int n;
        bit open;
        n = 0;
        in_valid = 1'b0;
        do begin
            open = 1'b0;
            for (int t = 0; t < 256; t++) if (pend[t]) open = 1'b1;
            if (open) @(negedge clk);
            n++;
        end while (open && n < 3000);
        chk(!open, req, "all rows emitted after drain", open, 0);
    endtask

    task automatic even_parity();
        int t;
        if (rows_sent % 2 == 1) begin
            send_row(1, t);
            drain("R2");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int ta, tb, tc, qb;
        for (int t = 0; t < 256; t++) begin pend[t] = 1'b0; exp_sum[t] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
        chk(throttle == 1'b0, "R9", "throttle after reset", throttle, 0);

        // R5 single-word latency on an idle block
        open_row(ta);
        exp_sum[ta] = 32'h1234_5678;
        in_valid = 1'b1; in_value = 32'h1234_5678; in_row = RW'(ta); in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (L) @(negedge clk);
        chk(out_valid == 1'b0, "R5", "no result before L+1 edges", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R5", "result at L+1 edges", out_valid, 1);
        chk(out_sum == 32'h1234_5678, "R5", "single word passes unchanged", out_sum, 32'h1234_5678);
        drain("R5");

        // R7 both lanes ready in the same cycle
        even_parity();
        qb = out_q.size();
        open_row(ta);
        exp_sum[ta] = 32'd7 + 32'd9;
        put(32'd7, RW'(ta), 1'b0);
        put(32'd9, RW'(ta), 1'b1);
        repeat (L - 1) @(negedge clk);
        open_row(tb);
        exp_sum[tb] = 32'd100;
        put(32'd100, RW'(tb), 1'b1);
        drain("R7");
        chk(out_q.size() == qb + 2, "R7", "two results", out_q.size() - qb, 2);
        if (out_q.size() == qb + 2) begin
            chk(out_q[qb] == ta, "R7", "lane 0 row first", out_q[qb], ta);
            chk(out_q[qb+1] == tb, "R7", "lane 1 row second", out_q[qb+1], tb);
            chk(out_c[qb+1] - out_c[qb] == 1, "R7", "lane 1 emits next cycle",
                out_c[qb+1] - out_c[qb], 1);
        end

        // R6 / R4 / R2: long row on lane 0, short rows behind it
        even_parity();
        qb = out_q.size();
        send_row(12, ta);
        send_row(1, tb);
        send_row(1, tc);
        drain("R6");
        chk(out_q.size() == qb + 3, "R6", "three results", out_q.size() - qb, 3);
        if (out_q.size() == qb + 3) begin
            chk(out_q[qb] == tb, "R6", "short lane 1 row leaves first", out_q[qb], tb);
            chk(out_q[qb+1] == ta, "R4", "long row before waiting row", out_q[qb+1], ta);
            chk(out_q[qb+2] == tc, "R4", "waiting lane 0 row last", out_q[qb+2], tc);
        end
        chk(saw_thr == 1'b0, "R8", "no throttle at low occupancy", saw_thr, 0);

        // R8 burst of single-word rows fills the FIFO
        for (int k = 0; k < 80; k++) send_row(1, ta);
        drain("R8");
        chk(saw_thr == 1'b1, "R8", "throttle raised during burst", saw_thr, 1);
        repeat (3) @(negedge clk);
        chk(throttle == 1'b0, "R8", "throttle released when empty", throttle, 0);

        // R10 / R3 back-to-back rows of mixed lengths
        for (int k = 0; k < 150; k++) send_row(1 + int'($urandom % 9), ta);
        drain("R10");
        drain("R3");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule